// File: doc/BRIEF.md
# Channel Request Enable and Pending Latch

This block sits between the request sources of a multi-channel DMA controller and its channel arbiter. It keeps one hardware-request enable bit per channel. Software can replace the whole bitmap in one write. It can also change one channel through a set port or a clear port, each of which takes a channel number, so no read-modify-write sequence is needed. Each of those two ports also has an "every channel" flag that sets or clears the whole bitmap in one cycle.

Three kinds of request come in. A peripheral request counts only while the enable bit of its channel is high. A software start request or a channel-link request counts whatever the enable bit holds. An accepted request is latched into a per-channel pending bit, and the bit stays high until the arbiter returns a service acknowledge for that channel. The arbiter reads the pending vector. Arbitration and data movement are outside this block.

Top module: `dma_chan_req_gate`

## Requirements
- R1: While `rst_n` is low, `enable_q` and `pend_q` are all zeros.
- R2: When `bm_wr_en` is high, every enable bit that no set or clear operation targets in that cycle takes the value of `bm_wr_data` after the next rising edge. With no write of any kind, the enable bits keep their values.
- R3: When `set_wr_en` is high and `set_all` is low, only bit `set_ch` of `enable_q` becomes 1 after the next edge. All other bits follow R2.
- R4: When `clr_wr_en` is high and `clr_all` is low, only bit `clr_ch` of `enable_q` becomes 0 after the next edge. All other bits follow R2.
- R5: `set_all` together with `set_wr_en` sets every enable bit. `clr_all` together with `clr_wr_en` clears every enable bit. In both cases the channel number is ignored.
- R6: A set or clear operation beats a bitmap write in the same cycle for the channels it targets. When a set and a clear target the same channel in one cycle, the clear wins (default `CLEAR_WINS` = 1).
- R7: `periph_req[i]` makes channel i pending after the next edge only if `enable_q[i]` is high in that cycle. Otherwise it has no effect on `pend_q[i]`.
- R8: `sw_start[i]` or `link_req[i]` makes channel i pending after the next edge, whatever the value of `enable_q[i]`.
- R9: `pend_q[i]` stays high until a cycle with `svc_ack[i]` high, and it is low after that edge. If a request for channel i is accepted in the same cycle as the acknowledge, the pending bit stays high.
- R10: A set or clear channel number of `NUM_CH` or above changes no enable bit (with the default 12 channels, the numbers 12 to 15 are ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bm_wr_en | input | 1 | Write the full enable bitmap |
| bm_wr_data | input | NUM_CH | New bitmap value |
| set_wr_en | input | 1 | Set-one operation strobe |
| set_all | input | 1 | Set every channel instead of one |
| set_ch | input | CH_W | Channel to set |
| clr_wr_en | input | 1 | Clear-one operation strobe |
| clr_all | input | 1 | Clear every channel instead of one |
| clr_ch | input | CH_W | Channel to clear |
| periph_req | input | NUM_CH | Peripheral hardware requests (gated) |
| sw_start | input | NUM_CH | Software start requests (ungated) |
| link_req | input | NUM_CH | Channel-link requests (ungated) |
| svc_ack | input | NUM_CH | Service acknowledge pulses from the arbiter |
| enable_q | output | NUM_CH | Current enable bitmap (read-back) |
| pend_q | output | NUM_CH | Pending request per channel |

## Verification
A corrupted enable bit is visible on `enable_q` one edge after the write that caused it. It then shows up again on `pend_q` one edge after the next peripheral request for that channel, where a request is either accepted or dropped when it should not be. A wrong pending bit appears on `pend_q` right away. It then persists, because nothing but an acknowledge clears it. Comparing both vectors against a behavioural model on every cycle therefore finds such a fault within one or two cycles of its cause. The tests cover priority collisions, out-of-range channel numbers and acknowledges that arrive together with a new request.

// File: rtl/dma_rqen_pkg.sv
package dma_rqen_pkg;
   // Index width for a channel number; never below one bit.
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   localparam int MAX_CH = 64;
endpackage

// File: rtl/rqen_decode.sv
module rqen_decode #(
   parameter int NUM_CH = 12,
   localparam int CH_W = dma_rqen_pkg::idx_w(NUM_CH)
) (
   input  logic              wr_en,
   input  logic              all,
   input  logic [CH_W-1:0]   ch,
   output logic [NUM_CH-1:0] mask
);
   // A number at or above NUM_CH matches no channel, so it selects nothing.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign mask[c] = wr_en & (all | (ch == CH_W'(c)));
   end
endmodule

// File: rtl/rqen_bits.sv
module rqen_bits #(
   parameter int NUM_CH     = 12,
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bm_wr_en,
   input  logic [NUM_CH-1:0] bm_wr_data,
   input  logic [NUM_CH-1:0] set_mask,
   input  logic [NUM_CH-1:0] clr_mask,
   output logic [NUM_CH-1:0] en_q
);
   logic [NUM_CH-1:0] base;
   logic [NUM_CH-1:0] en_d;

   assign base = bm_wr_en ? bm_wr_data : en_q;

   if (CLEAR_WINS) begin : g_clr_wins
      assign en_d = (base | set_mask) & ~clr_mask;
   end else begin : g_set_wins
      assign en_d = (base & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_mask & ~clr_mask)) |=>
         ((en_q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & ~set_mask)) |=> ((en_q & $past(clr_mask & ~set_mask)) == '0));

   p_bitmap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bm_wr_en |=> (((en_q ^ $past(bm_wr_data)) & ~$past(set_mask | clr_mask)) == '0));

   p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bm_wr_en |=> (((en_q ^ $past(en_q)) & ~$past(set_mask | clr_mask)) == '0));
endmodule

// File: rtl/rqen_pend.sv
module rqen_pend #(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] periph_req,
   input  logic [NUM_CH-1:0] sw_start,
   input  logic [NUM_CH-1:0] link_req,
   input  logic [NUM_CH-1:0] svc_ack,
   output logic [NUM_CH-1:0] pend_q
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      // Only the peripheral source is gated by the enable bit.
      assign hit = (periph_req[i] & en[i]) | sw_start[i] | link_req[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend_q[i] <= 1'b0;
         else if (hit)    pend_q[i] <= 1'b1;
         else if (svc_ack[i]) pend_q[i] <= 1'b0;
      end

      p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (periph_req[i] && en[i]) |=> pend_q[i]);

      p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!en[i] && !sw_start[i] && !link_req[i] && !pend_q[i]) |=> !pend_q[i]);

      p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_start[i] || link_req[i]) |=> pend_q[i]);

      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[i] && !svc_ack[i]) |=> pend_q[i]);

      p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (svc_ack[i] && !periph_req[i] && !sw_start[i] && !link_req[i]) |=> !pend_q[i]);
   end
endmodule

// File: rtl/dma_chan_req_gate.sv
module dma_chan_req_gate #(
   parameter int NUM_CH     = 12,
   parameter bit CLEAR_WINS = 1'b1,
   localparam int CH_W = dma_rqen_pkg::idx_w(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bm_wr_en,
   input  logic [NUM_CH-1:0] bm_wr_data,
   input  logic              set_wr_en,
   input  logic              set_all,
   input  logic [CH_W-1:0]   set_ch,
   input  logic              clr_wr_en,
   input  logic              clr_all,
   input  logic [CH_W-1:0]   clr_ch,
   input  logic [NUM_CH-1:0] periph_req,
   input  logic [NUM_CH-1:0] sw_start,
   input  logic [NUM_CH-1:0] link_req,
   input  logic [NUM_CH-1:0] svc_ack,
   output logic [NUM_CH-1:0] enable_q,
   output logic [NUM_CH-1:0] pend_q
);
   if (NUM_CH < 1 || NUM_CH > dma_rqen_pkg::MAX_CH) begin : g_bad_cfg
      $error("dma_chan_req_gate: NUM_CH out of supported range");
   end

   logic [NUM_CH-1:0] set_mask;
   logic [NUM_CH-1:0] clr_mask;

   rqen_decode #(.NUM_CH(NUM_CH)) u_set_dec (
      .wr_en (set_wr_en),
      .all   (set_all),
      .ch    (set_ch),
      .mask  (set_mask)
   );

   rqen_decode #(.NUM_CH(NUM_CH)) u_clr_dec (
      .wr_en (clr_wr_en),
      .all   (clr_all),
      .ch    (clr_ch),
      .mask  (clr_mask)
   );

   rqen_bits #(.NUM_CH(NUM_CH), .CLEAR_WINS(CLEAR_WINS)) u_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .bm_wr_en   (bm_wr_en),
      .bm_wr_data (bm_wr_data),
      .set_mask   (set_mask),
      .clr_mask   (clr_mask),
      .en_q       (enable_q)
   );

   rqen_pend #(.NUM_CH(NUM_CH)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enable_q),
      .periph_req (periph_req),
      .sw_start   (sw_start),
      .link_req   (link_req),
      .svc_ack    (svc_ack),
      .pend_q     (pend_q)
   );

   p_setall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr_en && set_all && !clr_wr_en) |=> (&enable_q));

   p_clrall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_en && clr_all) |=> (enable_q == '0));

   p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bm_wr_en && !clr_wr_en && set_wr_en && !set_all && (int'(set_ch) >= NUM_CH))
         |=> $stable(enable_q));
endmodule

// File: tb/sim_dma_chan_req_gate.sv
module sim_dma_chan_req_gate;
   localparam int N  = 12;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bm_wr_en = 1'b0;
   logic [N-1:0] bm_wr_data = '0;
   logic set_wr_en = 1'b0, set_all = 1'b0;
   logic [CW-1:0] set_ch = '0;
   logic clr_wr_en = 1'b0, clr_all = 1'b0;
   logic [CW-1:0] clr_ch = '0;
   logic [N-1:0] periph_req = '0, sw_start = '0, link_req = '0, svc_ack = '0;
   logic [N-1:0] enable_q, pend_q;

   int checks = 0;
   int errors = 0;
   string tag = "R1 reset";

   always #4 clk = ~clk;

   dma_chan_req_gate #(.NUM_CH(N)) u0 (
      .clk(clk), .rst_n(rst_n),
      .bm_wr_en(bm_wr_en), .bm_wr_data(bm_wr_data),
      .set_wr_en(set_wr_en), .set_all(set_all), .set_ch(set_ch),
      .clr_wr_en(clr_wr_en), .clr_all(clr_all), .clr_ch(clr_ch),
      .periph_req(periph_req), .sw_start(sw_start), .link_req(link_req),
      .svc_ack(svc_ack), .enable_q(enable_q), .pend_q(pend_q)
   );

   // Behavioural reference model
   bit [N-1:0] m_en, m_pend, nx_en, nx_pend;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_pend = '0;
      end else begin
         nx_en = m_en; nx_pend = m_pend;
         for (int c = 0; c < N; c++) begin
            if (bm_wr_en) nx_en[c] = bm_wr_data[c];
            if (set_wr_en && (set_all || int'(set_ch) == c)) nx_en[c] = 1'b1;
            if (clr_wr_en && (clr_all || int'(clr_ch) == c)) nx_en[c] = 1'b0;
            if (svc_ack[c]) nx_pend[c] = 1'b0;
            if ((periph_req[c] && m_en[c]) || sw_start[c] || link_req[c]) nx_pend[c] = 1'b1;
         end
         m_en = nx_en; m_pend = nx_pend;
      end
   end

   task automatic compare();
      checks++;
      if (enable_q !== m_en) begin
         errors++;
         $display("FAIL %s enable_q: actual %h expected %h", tag, enable_q, m_en);
      end
      checks++;
      if (pend_q !== m_pend) begin
         errors++;
         $display("FAIL %s pend_q: actual %h expected %h", tag, pend_q, m_pend);
      end
   endtask

   task automatic idle();
      bm_wr_en = 0; set_wr_en = 0; set_all = 0; clr_wr_en = 0; clr_all = 0;
      periph_req = '0; sw_start = '0; link_req = '0; svc_ack = '0;
   endtask

   task automatic step();
      @(negedge clk);
      compare();
   endtask

   always @(negedge clk) if (rst_n) compare();

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      @(negedge clk); rst_n = 1'b1;

      tag = "R2 bitmap write";
      bm_wr_en = 1; bm_wr_data = 12'hA5A; @(negedge clk); idle(); @(negedge clk);
      tag = "R3 set one";
      set_wr_en = 1; set_ch = 0; @(negedge clk); set_ch = 11; @(negedge clk); idle(); @(negedge clk);
      tag = "R10 out of range";
      set_wr_en = 1; set_ch = 13; @(negedge clk); set_ch = 4'd0; idle();
      clr_wr_en = 1; clr_ch = 15; @(negedge clk); idle(); @(negedge clk);
      tag = "R4 clear one";
      clr_wr_en = 1; clr_ch = 1; @(negedge clk); idle(); @(negedge clk);
      tag = "R5 set all";
      set_wr_en = 1; set_all = 1; set_ch = 2; @(negedge clk); idle(); @(negedge clk);
      tag = "R5 clear all";
      clr_wr_en = 1; clr_all = 1; clr_ch = 3; @(negedge clk); idle(); @(negedge clk);
      tag = "R6 single beats bitmap";
      bm_wr_en = 1; bm_wr_data = '0; set_wr_en = 1; set_ch = 5;
      clr_wr_en = 1; clr_ch = 7; @(negedge clk); idle();
      bm_wr_en = 1; bm_wr_data = '1; clr_wr_en = 1; clr_ch = 7; @(negedge clk); idle();
      tag = "R6 clear beats set";
      set_wr_en = 1; set_ch = 9; clr_wr_en = 1; clr_ch = 9; @(negedge clk); idle(); @(negedge clk);
      tag = "R7 gated peripheral";
      bm_wr_en = 1; bm_wr_data = 12'h0F3; @(negedge clk); idle();
      periph_req = '1; @(negedge clk); idle(); @(negedge clk);
      tag = "R9 ack clears";
      svc_ack = 12'h003; @(negedge clk); idle(); @(negedge clk);
      tag = "R9 ack with new request";
      svc_ack = 12'h030; periph_req = 12'h010; @(negedge clk); idle(); @(negedge clk);
      tag = "R8 bypass";
      clr_wr_en = 1; clr_all = 1; @(negedge clk); idle();
      svc_ack = '1; @(negedge clk); idle();
      sw_start = 12'h801; link_req = 12'h100; periph_req = 12'h0F0; @(negedge clk); idle(); @(negedge clk);

      tag = "random mix";
      for (int k = 0; k < 3000; k++) begin
         bm_wr_en   = ($urandom_range(0, 7) == 0);
         bm_wr_data = N'($urandom);
         set_wr_en  = ($urandom_range(0, 3) == 0);
         set_all    = ($urandom_range(0, 15) == 0);
         set_ch     = CW'($urandom_range(0, 15));
         clr_wr_en  = ($urandom_range(0, 3) == 0);
         clr_all    = ($urandom_range(0, 15) == 0);
         clr_ch     = CW'($urandom_range(0, 15));
         periph_req = N'($urandom);
         sw_start   = N'($urandom & $urandom & $urandom & $urandom);
         link_req   = N'($urandom & $urandom & $urandom & $urandom);
         svc_ack    = N'($urandom & $urandom);
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // Reset-state check (R1) while reset is held
   initial begin
      @(negedge clk);
      checks++;
      if (enable_q !== '0 || pend_q !== '0) begin
         errors++;
         $display("FAIL R1 reset: actual %h/%h expected 0/0", enable_q, pend_q);
      end
   end
endmodule